// File: doc/BRIEF.md
# Pairable Event Counter Bank

A bank of six event counters for performance monitoring. Each counter has a 64-bit configuration word and a 48-bit count register. Both are reached through one register port, with writes taking effect on a clock edge and reads returning combinationally. A set of event lanes feeds the bank. Each lane carries an 8-bit per-cycle event amount. An enabled counter uses the event code in its configuration to pick one lane, and adds that lane's low nibble to its count every cycle.

Some events can exceed fifteen occurrences per cycle. For those, an even counter and the odd counter above it can be fused into one wide counter. Software first programs the odd counter with the reserved merge code, then enables the even counter with the real event. While the pair is fused, it adds the lane's full 8-bit amount each cycle into a 64-bit total. The even register holds bits 47:0 of that total and the low 16 bits of the odd register hold bits 63:48.

When a count wraps, a sticky per-counter flag is set, and a level interrupt output reflects whether any flag is set.

Top module: `pecb_bank`

## Requirements
- R1: After reset, every configuration word and every count reads as zero, all overflow flags are clear and `irq` is low.
- R2: Register address `{index[2:0], sel}` selects counter `index`, with `sel`=0 for the configuration word and `sel`=1 for the count. A configuration write stores all 64 bits, and a read returns them unchanged. The configuration fields are: event code low byte in [7:0], unit mask in [15:8], enable in bit 22, event code high nibble in [35:32].
- R3: Lane n occupies `evt_lanes[8n+7:8n]`. A counter counts only when all three of these hold: it is enabled, its unit mask is nonzero, and its 12-bit event code n is below 8. Each cycle it then adds the low 4 bits of lane n to its 48-bit count. In every other case it adds nothing.
- R4: An odd counter enabled with event code 0xFFF merges its pair. While the pair is merged and the even counter is counting, each cycle adds the full 8-bit value of the even counter's lane to the 64-bit value {odd[15:0], even[47:0]}, and the carry passes from the even register into the odd register.
- R5: While a pair is merged, a read of the even count returns {odd[15:0], even[47:0]}. Outside merged mode it returns the even count zero-extended. A read of an odd count always returns its 48 bits zero-extended. A count write loads bits 47:0 of the write data into that one register only.
- R6: An even counter enabled while its partner is not merged counts as an ordinary counter: 4-bit increments, wrap at 2^48, and no effect on the odd counter.
- R7: An odd counter whose event code is not the merge code counts its own lane, independently of the even counter.
- R8: A count wrap sets that counter's sticky overflow flag. In normal mode the wrap is at 2^48. In merged mode the wrap is at 2^64, and the flag is set on the even counter. `irq` is high while any flag is set. Writing a counter's count register clears its flag.
- R9: When a count write and an increment fall on the same counter in the same cycle, the written value is stored. In a merged pair, a write to either count register drops that cycle's increment for the whole pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Counter index in [3:1]; [0] selects configuration (0) or count (1) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| evt_lanes | input | 64 | Eight 8-bit per-cycle event amounts |
| ovf_flags | output | 6 | Sticky overflow flag per counter |
| irq | output | 1 | High while any overflow flag is set |

## Verification
The bench targets four kinds of failure:
- **Lane amounts above fifteen on an unmerged counter.** A design that leaked the high nibble would over-count.
- **Carry across the 48-bit boundary in a fused pair.** A design that lost it would show bits 63:48 stuck, or would flag overflow at 2^48 instead of 2^64.
- **Write ordering.** A count write has to beat a same-cycle increment. A write to the odd half of a fused pair has to freeze the even half for that cycle. A design that got this wrong would show a value one increment too large.
- **Event codes whose high nibble is nonzero, disabled counters, and a zero unit mask.** A decoder that ignored any of these would count when it should not.

// File: rtl/pecb_pkg.sv
package pecb_pkg;
   localparam int CFG_W     = 64;
   localparam int CNT_W     = 48;
   localparam int WIDE_W    = 64;
   localparam int HI_W      = WIDE_W - CNT_W;
   localparam int LANE_W    = 8;
   localparam int NIB_W     = 4;
   localparam int CODE_W    = 12;
   localparam int UMASK_W   = 8;
   localparam logic [CODE_W-1:0] MERGE_CODE = 12'hFFF;

   typedef struct packed {
      logic               en;
      logic [UMASK_W-1:0] umask;
      logic [CODE_W-1:0]  code;
   } cfg_fields_t;

   function automatic cfg_fields_t unpack_cfg(input logic [CFG_W-1:0] w);
      cfg_fields_t f;
      f.en    = w[22];
      f.umask = w[15:8];
      f.code  = {w[35:32], w[7:0]};
      return f;
   endfunction
endpackage

// File: rtl/pecb_evt_sel.sv
module pecb_evt_sel
   import pecb_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int INC_W     = 8
) (
   input  cfg_fields_t                  cfg,
   input  logic [NUM_LANES*LANE_W-1:0]  lanes,
   output logic                         active,
   output logic                         merge_req,
   output logic [INC_W-1:0]             inc
);
   localparam int LIDX_W = $clog2(NUM_LANES);

   if (INC_W < 1 || INC_W > LANE_W) begin : g_bad_inc
      $error("pecb_evt_sel: INC_W must lie in 1..LANE_W");
   end

   logic [LIDX_W-1:0] idx;
   assign idx       = cfg.code[LIDX_W-1:0];
   assign active    = cfg.en && (cfg.umask != '0) && (cfg.code < CODE_W'(NUM_LANES));
   assign merge_req = cfg.en && (cfg.code == MERGE_CODE);

   always_comb begin
      inc = '0;
      for (int l = 0; l < NUM_LANES; l++) begin
         if (active && idx == LIDX_W'(l)) inc = lanes[l*LANE_W +: INC_W];
      end
   end
endmodule

// File: rtl/pecb_pair.sv
module pecb_pair
   import pecb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_e,
   input  logic [LANE_W-1:0] inc_e,
   input  logic [NIB_W-1:0]  inc_o,
   input  logic              merge_req,
   input  logic              wr_e,
   input  logic              wr_o,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  cnt_e,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              ovf_e,
   output logic              ovf_o,
   output logic              merged
);
   logic              fused;
   logic [CNT_W:0]    sum_e, sum_o;
   logic [WIDE_W:0]   sum_w;

   assign merged = merge_req;
   assign fused  = merge_req && act_e;
   assign sum_e  = {1'b0, cnt_e} + (CNT_W+1)'(inc_e[NIB_W-1:0]);
   assign sum_o  = {1'b0, cnt_o} + (CNT_W+1)'(inc_o);
   assign sum_w  = {1'b0, cnt_o[HI_W-1:0], cnt_e} + (WIDE_W+1)'(inc_e);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_e <= '0;
         cnt_o <= '0;
         ovf_e <= 1'b0;
         ovf_o <= 1'b0;
      end else begin
         if (wr_e) begin
            cnt_e <= wdata;
            ovf_e <= 1'b0;
         end else if (fused) begin
            if (!wr_o) begin
               cnt_e <= sum_w[CNT_W-1:0];
               if (sum_w[WIDE_W]) ovf_e <= 1'b1;
            end
         end else begin
            cnt_e <= sum_e[CNT_W-1:0];
            if (sum_e[CNT_W]) ovf_e <= 1'b1;
         end

         if (wr_o) begin
            cnt_o <= wdata;
            ovf_o <= 1'b0;
         end else if (fused) begin
            if (!wr_e) cnt_o[HI_W-1:0] <= sum_w[WIDE_W-1:CNT_W];
         end else begin
            cnt_o <= sum_o[CNT_W-1:0];
            if (sum_o[CNT_W]) ovf_o <= 1'b1;
         end
      end
   end

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_e |=> cnt_e == $past(wdata));
   assert_pair_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fused && wr_o && !wr_e) |=> cnt_e == $past(cnt_e));
   assert_narrow_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fused && !wr_e) |=> (cnt_e - $past(cnt_e)) <= CNT_W'(15));
   assert_odd_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fused && !wr_o) |=> cnt_o[CNT_W-1:HI_W] == $past(cnt_o[CNT_W-1:HI_W]));
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_e && !wr_e) |=> ovf_e);
   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> !ovf_o);
endmodule

// File: rtl/pecb_bank.sv
module pecb_bank
   import pecb_pkg::*;
#(
   parameter int NUM_CNT   = 6,
   parameter int NUM_LANES = 8,
   localparam int ADDR_W   = $clog2(NUM_CNT) + 1,
   localparam int LANES_W  = NUM_LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [CFG_W-1:0]   reg_wdata,
   output logic [WIDE_W-1:0]  reg_rdata,
   input  logic [LANES_W-1:0] evt_lanes,
   output logic [NUM_CNT-1:0] ovf_flags,
   output logic               irq
);
   localparam int NPAIR = NUM_CNT / 2;
   localparam int IDX_W = ADDR_W - 1;

   if (NUM_CNT < 2 || (NUM_CNT % 2) != 0) begin : g_bad_cnt
      $error("pecb_bank: NUM_CNT must be even and at least 2");
   end
   if (NUM_LANES < 2 || (NUM_LANES & (NUM_LANES - 1)) != 0 || NUM_LANES > 256) begin : g_bad_lanes
      $error("pecb_bank: NUM_LANES must be a power of two in 2..256");
   end

   logic [IDX_W-1:0]   idx;
   logic [CFG_W-1:0]   cfg_q [NUM_CNT];
   logic [CNT_W-1:0]   cnt_q [NUM_CNT];
   logic [NUM_CNT-1:0] wr_cnt;
   logic [NPAIR-1:0]   pair_merged;

   assign idx = reg_addr[ADDR_W-1:1];

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cfg
      assign wr_cnt[i] = reg_we && reg_addr[0] && (idx == IDX_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) cfg_q[i] <= '0;
         else if (reg_we && !reg_addr[0] && idx == IDX_W'(i)) cfg_q[i] <= reg_wdata;
      end
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic              act_e, act_o, mrg_e, mrg_o;
      logic [LANE_W-1:0] inc_e;
      logic [NIB_W-1:0]  inc_o;

      // even member: full-width lane pick, since it may feed a fused pair
      pecb_evt_sel #(.NUM_LANES(NUM_LANES), .INC_W(LANE_W)) u_sel_e (
         .cfg(unpack_cfg(cfg_q[2*p])), .lanes(evt_lanes),
         .active(act_e), .merge_req(mrg_e), .inc(inc_e));
      // odd member: narrow pick only, its own count never takes 8 bits
      pecb_evt_sel #(.NUM_LANES(NUM_LANES), .INC_W(NIB_W)) u_sel_o (
         .cfg(unpack_cfg(cfg_q[2*p+1])), .lanes(evt_lanes),
         .active(act_o), .merge_req(mrg_o), .inc(inc_o));

      pecb_pair u_pair (
         .clk(clk), .rst_n(rst_n),
         .act_e(act_e), .inc_e(inc_e), .inc_o(inc_o),
         .merge_req(mrg_o),
         .wr_e(wr_cnt[2*p]), .wr_o(wr_cnt[2*p+1]),
         .wdata(reg_wdata[CNT_W-1:0]),
         .cnt_e(cnt_q[2*p]), .cnt_o(cnt_q[2*p+1]),
         .ovf_e(ovf_flags[2*p]), .ovf_o(ovf_flags[2*p+1]),
         .merged(pair_merged[p]));

      // the merge code on an even counter selects no lane, so it stays idle
      assert_even_merge_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mrg_e && !reg_we) |=> !act_e);
      // an odd counter holding the merge code never counts its own lane
      assert_merge_odd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
         mrg_o |-> (!act_o && inc_o == '0));
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (idx == IDX_W'(i)) begin
            if (!reg_addr[0])
               reg_rdata = cfg_q[i];
            else if ((i % 2) == 0 && pair_merged[i/2])
               reg_rdata = {cnt_q[i | 1][HI_W-1:0], cnt_q[i]};
            else
               reg_rdata = {{HI_W{1'b0}}, cnt_q[i]};
         end
      end
   end

   assign irq = |ovf_flags;

   assert_irq_follows_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $countones(ovf_flags) > 0);
endmodule

// File: tb/tb_pecb_bank.sv
module tb_pecb_bank;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we;
   logic [3:0]  reg_addr;
   logic [63:0] reg_wdata;
   logic [63:0] reg_rdata;
   logic [63:0] evt_lanes;
   logic [5:0]  ovf_flags;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pecb_bank dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_lanes(evt_lanes),
      .ovf_flags(ovf_flags), .irq(irq));

   // en, code[11:0], umask, lane value, cycles, expected count
   localparam int NV = 7;
   localparam logic [68:0] VEC [NV] = '{
      {1'b1, 12'h003, 8'h01, 8'h05, 8'd4,  32'd20},
      {1'b1, 12'h003, 8'h00, 8'h05, 8'd4,  32'd0},
      {1'b1, 12'h009, 8'hFF, 8'h05, 8'd4,  32'd0},
      {1'b1, 12'h007, 8'h80, 8'h2B, 8'd3,  32'd33},
      {1'b1, 12'h000, 8'h10, 8'h0F, 8'd10, 32'd150},
      {1'b1, 12'h105, 8'h01, 8'h07, 8'd2,  32'd0},
      {1'b0, 12'h002, 8'h01, 8'h06, 8'd5,  32'd0}
   };

   function automatic logic [63:0] mk_cfg(input logic [11:0] code, input logic [7:0] um, input logic en);
      logic [63:0] w = '0;
      w[7:0]   = code[7:0];
      w[15:8]  = um;
      w[22]    = en;
      w[35:32] = code[11:8];
      return w;
   endfunction

   task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", what, got, exp);
      end
   endtask

   // tasks start just after a falling edge
   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      logic [63:0] base;
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; evt_lanes = '0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      for (int a = 0; a < 12; a++) begin
         rd(4'(a), v);
         chk($sformatf("R1 reset reg %0d", a), v, 64'h0);
         cyc(1);
      end
      chk("R1 reset flags", {58'h0, ovf_flags}, 64'h0);
      chk("R1 reset irq", {63'h0, irq}, 64'h0);

      // R2 configuration readback
      wr(4'd8, 64'hDEAD_BEEF_0123_4567);
      rd(4'd8, v);
      chk("R2 cfg readback", v, 64'hDEAD_BEEF_0123_4567);
      cyc(1);
      wr(4'd8, 64'h0);

      // R3 vector table on counter 0
      for (int k = 0; k < NV; k++) begin
         wr(4'd0, mk_cfg(VEC[k][67:56], VEC[k][55:48], VEC[k][68]));
         wr(4'd1, 64'h0);
         evt_lanes = 64'(VEC[k][47:40]) << (8 * int'(VEC[k][58:56]));
         cyc(int'(VEC[k][39:32]));
         evt_lanes = '0;
         rd(4'd1, v);
         chk($sformatf("R3 vector %0d", k), v, {32'h0, VEC[k][31:0]});
         cyc(1);
      end

      // R7 odd counter counts its own lane next to the even one
      wr(4'd0, mk_cfg(12'h003, 8'h01, 1'b1));
      wr(4'd2, mk_cfg(12'h002, 8'h01, 1'b1));
      wr(4'd1, 64'h0);
      wr(4'd3, 64'h0);
      evt_lanes = (64'h05 << 24) | (64'h04 << 16);
      cyc(6);
      evt_lanes = '0;
      rd(4'd1, v);
      chk("R7 even neighbour", v, 64'd30);
      rd(4'd3, v);
      chk("R7 odd independent", v, 64'd24);
      cyc(1);
      wr(4'd0, 64'h0);
      wr(4'd2, 64'h0);

      // R6 even counter before partner merged: narrow only
      wr(4'd4, mk_cfg(12'h001, 8'h01, 1'b1));
      evt_lanes = 64'h9A << 8;
      cyc(3);
      evt_lanes = '0;
      rd(4'd5, v);
      chk("R6 unmerged even truncates", v, 64'd30);
      rd(4'd7, v);
      chk("R6 partner untouched", v, 64'd0);
      cyc(1);

      // R4 merge the pair 2/3
      wr(4'd6, mk_cfg(12'hFFF, 8'hFF, 1'b1));
      wr(4'd5, 64'h0);
      evt_lanes = 64'h9A << 8;
      cyc(3);
      evt_lanes = '0;
      rd(4'd5, v);
      chk("R4 merged full byte", v, 64'd462);
      cyc(1);

      // R5 split read/write and R4 carry
      wr(4'd7, 64'h1234);
      wr(4'd5, 64'hABCD_FFFF_FFFF_FFF0);
      rd(4'd5, v);
      chk("R5 merged read after low write", v, 64'h1234_FFFF_FFFF_FFF0);
      cyc(1);
      evt_lanes = 64'h20 << 8;
      cyc(1);
      evt_lanes = '0;
      rd(4'd5, v);
      chk("R4 carry into odd", v, 64'h1235_0000_0000_0010);
      rd(4'd7, v);
      chk("R5 odd read", v, 64'h1235);
      cyc(1);

      // R8 merged wrap at 2^64
      wr(4'd7, 64'hFFFF);
      wr(4'd5, 64'hFFFF_FFFF_FFFF);
      chk("R8 irq low before wrap", {63'h0, irq}, 64'h0);
      evt_lanes = 64'h02 << 8;
      cyc(1);
      evt_lanes = '0;
      rd(4'd5, v);
      chk("R8 merged wrap value", v, 64'h1);
      chk("R8 merged flag on even", {58'h0, ovf_flags}, 64'h04);
      chk("R8 irq raised", {63'h0, irq}, 64'h1);
      cyc(2);
      chk("R8 flag sticky", {58'h0, ovf_flags}, 64'h04);
      wr(4'd5, 64'h5);
      chk("R8 flag cleared by write", {58'h0, ovf_flags}, 64'h0);
      chk("R8 irq cleared", {63'h0, irq}, 64'h0);

      // R9 odd write drops the pair's increment
      evt_lanes = 64'h10 << 8;
      rd(4'd5, base);
      wr(4'd7, 64'h7);
      rd(4'd5, v);
      chk("R9 pair increment dropped", v, {16'h0007, base[47:0]});
      cyc(1);
      rd(4'd5, v);
      chk("R9 pair resumes", v, {16'h0007, base[47:0] + 48'h10});
      evt_lanes = '0;
      cyc(1);

      // R9 write beats increment on a normal counter
      wr(4'd0, mk_cfg(12'h003, 8'h01, 1'b1));
      evt_lanes = 64'h05 << 24;
      cyc(2);
      wr(4'd1, 64'd100);
      rd(4'd1, v);
      chk("R9 write wins", v, 64'd100);
      cyc(1);
      rd(4'd1, v);
      chk("R9 counting after write", v, 64'd105);
      evt_lanes = '0;
      cyc(1);

      // R8 normal wrap at 2^48
      wr(4'd1, 64'hFFFF_FFFF_FFFE);
      evt_lanes = 64'h05 << 24;
      cyc(1);
      evt_lanes = '0;
      rd(4'd1, v);
      chk("R8 normal wrap value", v, 64'd3);
      chk("R8 normal flag", {58'h0, ovf_flags}, 64'h01);
      cyc(3);
      chk("R8 normal irq held", {63'h0, irq}, 64'h1);
      wr(4'd1, 64'h0);
      chk("R8 normal flag cleared", {58'h0, ovf_flags}, 64'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule